// File: doc/BRIEF.md
# DMA Control and Status Register Block with Interrupt Gating

This block holds the control and status registers that sit between a host register bus and a byte-wide SCSI bus controller paired with a DMA byte engine. The host writes a control word that sets transfer direction, pack mode, interrupt enable and DMA enable. The same word releases the FIFO and the controller from reset; both reset bits are active low, so the reset state holds both functions in reset. The block also holds a 32-bit DMA address, a 32-bit DMA transfer count and a 32-bit FIFO count. The host writes each of them as two 16-bit halves. The block latches transfer error events and reports the left-over byte count.

The DMA enable bit decides two things. It lets the engine run, and it also gates the controller's interrupt request on its way to the host. To receive a controller interrupt while idle, software enables DMA with a zero count, because the engine moves no data while the count is zero. While DMA is enabled, host accesses to the controller are refused and the refusal is recorded. The engine moves one byte per strobe. Each byte counts the transfer count and the FIFO count down and the address up, and the engine stops by itself when the count reaches zero.

Top module: `dmac_csr`

## Requirements
- R1: After reset, every control bit is 0, all counters read 0, `fifo_rst` and `ctl_rst` are 1, and `dma_run`, `host_irq` and `ctl_acc_ok` are 0.
- R2: The control word is at register offset 0. Bit 0 releases the FIFO and bit 1 releases the controller; `fifo_rst` and `ctl_rst` are 1 while their bit is 0. Bit 2 is interrupt enable, bit 3 is DMA enable, bit 4 selects send (memory to SCSI) when set, and bit 5 is pack mode. Bits 5:0 read back as written.
- R3: `host_irq` is 1 only when `sbc_irq`, interrupt enable, DMA enable and `fifo_empty` are all 1 and the FIFO count is zero.
- R4: Offsets 1/2 hold the address high/low halves, 3/4 the transfer count high/low and 5/6 the FIFO count high/low. Each half reads back as written.
- R5: A write to either half of the transfer count also loads the same half of the FIFO count.
- R6: A write to the address low half stores bit 0 as 0, so the start address is always even.
- R7: `dma_run` is 1 only when DMA enable and the FIFO release bit are set and the transfer count is nonzero. Each `byte_stb` cycle while running decrements the transfer count and the FIFO count by one, with a borrow from the high half, and increments the address. Strobes at a zero count change nothing.
- R8: Status bit 8 latches a `conf_evt` pulse and bit 9 latches a `berr_evt` pulse. Both stay set until the FIFO release bit is written 0. While that bit is 0 the flags read 0 one cycle later, and events are ignored.
- R9: While DMA enable is 1, `ctl_acc_ok` stays 0 and a `ctl_acc` request sets status bit 10, which clears like the error flags. While DMA enable is 0, `ctl_acc_ok` follows `ctl_acc` in the same cycle.
- R10: Status bits 13:12 show `lob_cnt`. `dir_send` follows control bit 4, and `pack_mode` follows control bit 5 when `PACK_EN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| byte_stb | input | 1 | One byte moved this cycle |
| dma_run | output | 1 | Engine allowed to move data |
| dma_addr | output | 32 | Current DMA address |
| dir_send | output | 1 | 1 = memory to SCSI |
| pack_mode | output | 1 | Pack mode select |
| fifo_rst | output | 1 | FIFO held in reset |
| ctl_rst | output | 1 | Controller held in reset |
| fifo_empty | input | 1 | FIFO holds no data |
| lob_cnt | input | 2 | Left-over byte count |
| conf_evt | input | 1 | DMA conflict event |
| berr_evt | input | 1 | DMA bus-error event |
| sbc_irq | input | 1 | Controller interrupt request |
| host_irq | output | 1 | Gated interrupt to host |
| ctl_acc | input | 1 | Host requests controller access |
| ctl_acc_ok | output | 1 | Controller access allowed |

## Verification
Interrupt gating is driven from a vector table that drops one enabling condition at a time against an all-enabled case. This shows that DMA enable, interrupt enable, FIFO empty and the request itself are each needed; a directed case with a nonzero FIFO count covers the last condition. The counters are tried with a small count run past zero, which separates stopping from wrapping, and with a count of exactly 0x0001_0000, which exercises the borrow across halves. Error and access-refusal latching is tried with a plain rewrite of the control word and with a real reset pulse, which separates sticky flags from level-following ones.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_ADDR_HI = 3'd1,
      RA_ADDR_LO = 3'd2,
      RA_CNT_HI  = 3'd3,
      RA_CNT_LO  = 3'd4,
      RA_FCNT_HI = 3'd5,
      RA_FCNT_LO = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic pack;
      logic send;
      logic dma_en;
      logic irq_en;
      logic ctl_rel;
      logic fifo_rel;
   } ctrl_t;

   localparam int CTRL_W   = 6;
   localparam int ST_CONF  = 8;
   localparam int ST_BERR  = 9;
   localparam int ST_VIOL  = 10;
   localparam int ST_LOB   = 12;
endpackage

// File: rtl/dmac_cnt.sv
module dmac_cnt #(
   parameter int W       = 32,
   parameter int HW      = 16,
   parameter bit UP      = 1'b0,
   parameter bit CLR_LSB = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hi,
   input  logic          wr_lo,
   input  logic [HW-1:0] wdata,
   input  logic          step,
   output logic [W-1:0]  value,
   output logic          is_zero
);
   localparam int HI_W = W - HW;

   initial assert (W == 2 * HW) else $error("dmac_cnt: W must be twice HW");

   logic [HW-1:0] lo_data;
   logic [W-1:0]  stepped;
   logic          step_ok;

   generate
      if (CLR_LSB) begin : g_even
         assign lo_data = {wdata[HW-1:1], 1'b0};
      end else begin : g_plain
         assign lo_data = wdata;
      end
      if (UP) begin : g_up
         assign stepped = value + W'(1);
         assign step_ok = step;
      end else begin : g_down
         assign stepped = value - W'(1);
         assign step_ok = step && !is_zero;
      end
   endgenerate

   assign is_zero = (value == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr_hi || wr_lo) begin
         if (wr_hi) value[W-1:HW] <= wdata[HI_W-1:0];
         if (wr_lo) value[HW-1:0] <= lo_data;
      end else if (step_ok) begin
         value <= stepped;
      end
   end

   // R7
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!UP && is_zero && !wr_hi && !wr_lo) |=> is_zero);
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
   import dmac_pkg::*;
#(
   parameter bit PACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              conf_evt,
   input  logic              berr_evt,
   input  logic              viol_evt,
   output ctrl_t             ctrl,
   output logic              err_conf,
   output logic              err_berr,
   output logic              viol
);
   ctrl_t wr_val;

   generate
      if (PACK_EN) begin : g_pack
         assign wr_val = ctrl_t'(wdata);
      end else begin : g_nopack
         assign wr_val = ctrl_t'({1'b0, wdata[CTRL_W-2:0]});
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl <= '0;
      else if (wr) ctrl <= wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_conf <= 1'b0;
         err_berr <= 1'b0;
         viol     <= 1'b0;
      end else if (!ctrl.fifo_rel) begin
         err_conf <= 1'b0;
         err_berr <= 1'b0;
         viol     <= 1'b0;
      end else begin
         err_conf <= err_conf | conf_evt;
         err_berr <= err_berr | berr_evt;
         viol     <= viol | viol_evt;
      end
   end

   // R8
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.fifo_rel && (err_conf || err_berr)) |=> (err_conf || err_berr));

   // R8
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.fifo_rel |=> (!err_conf && !err_berr && !viol));
endmodule

// File: rtl/dmac_irq_gate.sv
module dmac_irq_gate (
   input  logic sbc_irq,
   input  logic irq_en,
   input  logic dma_en,
   input  logic fifo_empty,
   input  logic fcnt_zero,
   output logic host_irq
);
   logic quiet;
   assign quiet    = fifo_empty && fcnt_zero;
   assign host_irq = sbc_irq && irq_en && dma_en && quiet;
endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
   import dmac_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 32,
   parameter int LOB_W   = 2,
   parameter bit PACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              byte_stb,
   output logic              dma_run,
   output logic [CNT_W-1:0]  dma_addr,
   output logic              dir_send,
   output logic              pack_mode,
   output logic              fifo_rst,
   output logic              ctl_rst,
   input  logic              fifo_empty,
   input  logic [LOB_W-1:0]  lob_cnt,
   input  logic              conf_evt,
   input  logic              berr_evt,
   input  logic              sbc_irq,
   output logic              host_irq,
   input  logic              ctl_acc,
   output logic              ctl_acc_ok
);
   localparam int HW = CNT_W / 2;

   initial assert (DATA_W == 16) else $error("dmac_csr: DATA_W must be 16");
   initial assert (CNT_W == 2 * DATA_W) else $error("dmac_csr: CNT_W must be 2*DATA_W");
   initial assert (LOB_W >= 1 && LOB_W <= 3) else $error("dmac_csr: LOB_W out of range");

   ctrl_t             ctrl;
   logic              err_conf, err_berr, viol;
   logic [CNT_W-1:0]  cnt, fcnt;
   logic              cnt_zero, fcnt_zero, addr_zero;
   logic              step;
   logic              wr_ctrl, wr_ahi, wr_alo, wr_chi, wr_clo, wr_fhi, wr_flo;

   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_ahi  = reg_wr && (reg_addr == RA_ADDR_HI);
   assign wr_alo  = reg_wr && (reg_addr == RA_ADDR_LO);
   assign wr_chi  = reg_wr && (reg_addr == RA_CNT_HI);
   assign wr_clo  = reg_wr && (reg_addr == RA_CNT_LO);
   assign wr_fhi  = reg_wr && ((reg_addr == RA_FCNT_HI) || (reg_addr == RA_CNT_HI));
   assign wr_flo  = reg_wr && ((reg_addr == RA_FCNT_LO) || (reg_addr == RA_CNT_LO));

   dmac_ctrl #(.PACK_EN(PACK_EN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ctrl),
      .wdata    (reg_wdata[CTRL_W-1:0]),
      .conf_evt (conf_evt),
      .berr_evt (berr_evt),
      .viol_evt (ctl_acc && ctrl.dma_en),
      .ctrl     (ctrl),
      .err_conf (err_conf),
      .err_berr (err_berr),
      .viol     (viol)
   );

   assign dma_run = ctrl.dma_en && ctrl.fifo_rel && !cnt_zero;
   assign step    = byte_stb && dma_run;

   dmac_cnt #(.W(CNT_W), .HW(HW), .UP(1'b1), .CLR_LSB(1'b1)) u_addr (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_ahi), .wr_lo(wr_alo),
      .wdata(reg_wdata), .step(step), .value(dma_addr), .is_zero(addr_zero)
   );

   dmac_cnt #(.W(CNT_W), .HW(HW), .UP(1'b0), .CLR_LSB(1'b0)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_chi), .wr_lo(wr_clo),
      .wdata(reg_wdata), .step(step), .value(cnt), .is_zero(cnt_zero)
   );

   dmac_cnt #(.W(CNT_W), .HW(HW), .UP(1'b0), .CLR_LSB(1'b0)) u_fcnt (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_fhi), .wr_lo(wr_flo),
      .wdata(reg_wdata), .step(step), .value(fcnt), .is_zero(fcnt_zero)
   );

   dmac_irq_gate u_gate (
      .sbc_irq    (sbc_irq),
      .irq_en     (ctrl.irq_en),
      .dma_en     (ctrl.dma_en),
      .fifo_empty (fifo_empty),
      .fcnt_zero  (fcnt_zero),
      .host_irq   (host_irq)
   );

   assign dir_send   = ctrl.send;
   assign pack_mode  = ctrl.pack;
   assign fifo_rst   = !ctrl.fifo_rel;
   assign ctl_rst    = !ctrl.ctl_rel;
   assign ctl_acc_ok = ctl_acc && !ctrl.dma_en;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CTRL_W-1:0]          = ctrl;
            reg_rdata[ST_CONF]             = err_conf;
            reg_rdata[ST_BERR]             = err_berr;
            reg_rdata[ST_VIOL]             = viol;
            reg_rdata[ST_LOB +: LOB_W]     = lob_cnt;
         end
         RA_ADDR_HI: reg_rdata = dma_addr[CNT_W-1:HW];
         RA_ADDR_LO: reg_rdata = dma_addr[HW-1:0];
         RA_CNT_HI:  reg_rdata = cnt[CNT_W-1:HW];
         RA_CNT_LO:  reg_rdata = cnt[HW-1:0];
         RA_FCNT_HI: reg_rdata = fcnt[CNT_W-1:HW];
         RA_FCNT_LO: reg_rdata = fcnt[HW-1:0];
         default:    reg_rdata = '0;
      endcase
   end

   // R3
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (ctrl.dma_en && fcnt_zero));

   // R7
   run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_run |-> !cnt_zero);

   // R9
   acc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.dma_en |-> !ctl_acc_ok);

   // R6
   even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_alo |=> !dma_addr[0]);
endmodule

// File: tb/dmac_csr_tb.sv
module dmac_csr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        byte_stb = 1'b0;
   logic        dma_run;
   logic [31:0] dma_addr;
   logic        dir_send, pack_mode, fifo_rst, ctl_rst;
   logic        fifo_empty = 1'b0;
   logic [1:0]  lob_cnt = 2'd0;
   logic        conf_evt = 1'b0, berr_evt = 1'b0, sbc_irq = 1'b0;
   logic        host_irq;
   logic        ctl_acc = 1'b0;
   logic        ctl_acc_ok;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dmac_csr u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_stb(byte_stb),
      .dma_run(dma_run), .dma_addr(dma_addr), .dir_send(dir_send),
      .pack_mode(pack_mode), .fifo_rst(fifo_rst), .ctl_rst(ctl_rst),
      .fifo_empty(fifo_empty), .lob_cnt(lob_cnt), .conf_evt(conf_evt),
      .berr_evt(berr_evt), .sbc_irq(sbc_irq), .host_irq(host_irq),
      .ctl_acc(ctl_acc), .ctl_acc_ok(ctl_acc_ok)
   );

   // {sbc_irq, irq_en, dma_en, fifo_empty, expected host_irq}
   localparam logic [4:0] IRQ_VEC [8] = '{
      5'b1111_1, 5'b0111_0, 5'b1011_0, 5'b1101_0,
      5'b1110_0, 5'b0000_0, 5'b1001_0, 5'b1111_1
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic strobe();
      @(negedge clk);
      byte_stb = 1'b1;
      @(negedge clk);
      byte_stb = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) conf_evt = 1'b1; else berr_evt = 1'b1;
      @(negedge clk);
      conf_evt = 1'b0; berr_evt = 1'b0;
   endtask

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d); chk("R1 ctrl", d, 16'h0000);
      rd(3'd4, d); chk("R1 cnt", d, 16'h0000);
      chk("R1 resets", {fifo_rst, ctl_rst}, 2'b11);
      chk("R1 outs", {dma_run, host_irq, ctl_acc_ok}, 3'b000);

      // R2 control layout
      wr(3'd0, 16'h0003);
      chk("R2 released", {fifo_rst, ctl_rst}, 2'b00);
      wr(3'd0, 16'h0031);
      chk("R2 ctl held", {fifo_rst, ctl_rst}, 2'b01);
      rd(3'd0, d); chk("R2 readback", d, 16'h0031);
      // R10 direction and pack follow bits 4 and 5
      chk("R10 send/pack", {dir_send, pack_mode}, 2'b11);
      wr(3'd0, 16'h0003);

      // R3 interrupt gating table
      for (int i = 0; i < 8; i++) begin
         wr(3'd0, {12'd0, IRQ_VEC[i][2], IRQ_VEC[i][3], 2'b11});
         sbc_irq = IRQ_VEC[i][4];
         fifo_empty = IRQ_VEC[i][1];
         #1;
         chk($sformatf("R3 vec %0d", i), host_irq, IRQ_VEC[i][0]);
      end
      // R3 nonzero FIFO count suppresses
      wr(3'd6, 16'h0005);
      #1; chk("R3 fcnt nonzero", host_irq, 1'b0);
      wr(3'd6, 16'h0000);
      #1; chk("R3 fcnt zero", host_irq, 1'b1);
      sbc_irq = 1'b0; fifo_empty = 1'b0;
      wr(3'd0, 16'h0003);

      // R4 / R6 address halves, even start
      wr(3'd1, 16'hABCD);
      wr(3'd2, 16'h1235);
      rd(3'd1, d); chk("R4 addr hi", d, 16'hABCD);
      rd(3'd2, d); chk("R6 addr lo even", d, 16'h1234);
      // R4 / R5 count loads FIFO count
      wr(3'd3, 16'h0000);
      wr(3'd4, 16'h0003);
      rd(3'd4, d); chk("R4 cnt lo", d, 16'h0003);
      rd(3'd6, d); chk("R5 fcnt lo", d, 16'h0003);
      wr(3'd5, 16'h0007);
      rd(3'd5, d); chk("R4 fcnt hi", d, 16'h0007);
      rd(3'd3, d); chk("R4 cnt hi untouched", d, 16'h0000);
      wr(3'd5, 16'h0000);
      chk("R7 idle when disabled", dma_run, 1'b0);

      // R7 run, count down, stop at zero
      wr(3'd0, 16'h000A);
      chk("R7 fifo held blocks run", dma_run, 1'b0);
      wr(3'd0, 16'h000B);
      chk("R7 run", dma_run, 1'b1);
      strobe(); strobe(); strobe();
      chk("R7 stopped", dma_run, 1'b0);
      strobe();
      rd(3'd4, d); chk("R7 cnt zero", d, 16'h0000);
      rd(3'd6, d); chk("R7 fcnt zero", d, 16'h0000);
      chk("R7 addr", dma_addr, 32'hABCD_1237);
      // R7 borrow across halves
      wr(3'd0, 16'h0003);
      wr(3'd3, 16'h0001);
      wr(3'd4, 16'h0000);
      wr(3'd0, 16'h000B);
      strobe();
      rd(3'd3, d); chk("R7 borrow hi", d, 16'h0000);
      rd(3'd4, d); chk("R7 borrow lo", d, 16'hFFFF);
      chk("R7 addr step", dma_addr, 32'hABCD_1238);

      // R9 controller access refused while DMA enabled
      @(negedge clk); ctl_acc = 1'b1;
      #1; chk("R9 refused", ctl_acc_ok, 1'b0);
      @(negedge clk); ctl_acc = 1'b0;
      wr(3'd0, 16'h0003);
      rd(3'd0, d); chk("R9 flag", d[10], 1'b1);
      ctl_acc = 1'b1;
      #1; chk("R9 allowed", ctl_acc_ok, 1'b1);
      ctl_acc = 1'b0;

      // R8 sticky error flags
      pulse(0);
      rd(3'd0, d); chk("R8 conflict", d[9:8], 2'b01);
      pulse(1);
      wr(3'd0, 16'h0003);
      rd(3'd0, d); chk("R8 sticky", d[10:8], 3'b111);
      wr(3'd0, 16'h0002);
      @(negedge clk);
      rd(3'd0, d); chk("R8 cleared", d[10:8], 3'b000);
      pulse(0);
      rd(3'd0, d); chk("R8 ignored in reset", d[8], 1'b0);
      wr(3'd0, 16'h0003);

      // R10 left-over count
      lob_cnt = 2'b10;
      rd(3'd0, d); chk("R10 lob", d[13:12], 2'b10);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule